// File: doc/BRIEF.md
# Low Pin Count Memory Cycle Target

This block is the bus-facing front end of a memory device on a Low Pin Count bus. It watches the active-low frame strobe and the 4-bit multiplexed LAD bus. It recognises single-byte memory read and write cycles and collects the address and write data nibble by nibble. It checks that the cycle carries the chip's own ID, set by four strap inputs. It then asks a local memory array for the byte through a level request with a one-clock acknowledge. While the request is open it answers the host with short-wait SYNC nibbles. It drives a ready SYNC and, for reads, the data byte. It then hands the bus back after a turnaround.

The host may pull the frame strobe low at any clock. That clock releases LAD at once and returns the target to START detection. The nibble seen in that clock counts as a START candidate for the next frame. LAD is modelled as a separate input, output and output-enable, and a pad ring outside the block joins them.

States of the controller: `ST_IDLE` (START detection and idle), `ST_ADDR` (eight address nibbles), `ST_WDAT_LO` / `ST_WDAT_HI` (write data), `ST_HTAR_A` / `ST_HTAR_B` (host-to-target turnaround), `ST_SYNC_WAIT` (request open, short wait), `ST_SYNC_OK` (ready SYNC), `ST_RDAT_LO` / `ST_RDAT_HI` (read data), `ST_TTAR_A` / `ST_TTAR_B` (target-to-host turnaround). The transitions are:
- IDLE→ADDR on a memory frame.
- ADDR→WDAT_LO (write with ID hit), ADDR→HTAR_A (read with ID hit) or ADDR→IDLE (ID miss) after the last address nibble.
- WDAT_LO→WDAT_HI→HTAR_A→HTAR_B→SYNC_WAIT.
- SYNC_WAIT→SYNC_OK on acknowledge.
- SYNC_OK→RDAT_LO (read) or SYNC_OK→TTAR_A (write), then RDAT_LO→RDAT_HI→TTAR_A→TTAR_B→IDLE.
- Any state goes to IDLE when the frame strobe is low.

Top module: `lpc_mem_target`

## Requirements
- R1: After synchronous reset, `lad_oe` and `mem_req` are 0.
- R2: START is the LAD nibble of the last clock with `lframe_n` low. A cycle begins only if that nibble is 4'b0000. Any other START leaves the target silent, with no request and no drive.
- R3: The nibble in the first clock with `lframe_n` high is the cycle type. Bits [3:2] = 2'b01 mean memory, and bit 1 = 1 means write, 0 means read. Any other type is ignored.
- R4: The 32-bit address follows in eight nibbles, most significant first, and is presented on `mem_addr` while `mem_req` is high.
- R5: The cycle is served only if address bits [25:22] equal `id_strap`. Otherwise the target stays silent for the rest of the frame.
- R6: For a write, two data nibbles follow the address, low nibble first. `mem_we` is 1 and `mem_wdata` holds the byte during the request.
- R7: After the last host nibble come two turnaround clocks with LAD not driven. The SYNC phase starts in the third clock.
- R8: Throughout the SYNC phase `mem_req` stays high until `mem_ack`, and the target drives SYNC 4'b0101 (short wait). At least one wait nibble is always sent.
- R9: In the clock after `mem_ack`, the target drives SYNC 4'b0000 (ready) and `mem_req` is low.
- R10: For a read, the two clocks after the ready SYNC carry `mem_rdata` low nibble then high nibble. After the ready SYNC (write) or the data (read), there are two clocks with LAD not driven.
- R11: `lframe_n` low releases LAD in the same clock. In the next clock there is no request. That clock's nibble acts as a START candidate.
- R12: `lad_oe` is 1 only in the SYNC and read-data phases, never in host phases or idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lframe_n | input | 1 | Active-low frame / abort strobe from host |
| lad_in | input | 4 | LAD nibble as seen at the pad |
| lad_out | output | 4 | Nibble the target drives |
| lad_oe | output | 1 | Output enable for LAD |
| id_strap | input | 4 | Chip ID straps |
| mem_req | output | 1 | Request to the local array, held until acknowledge |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | One-clock acknowledge from the array |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |

## Verification
In a frame whose START clock is k, the request and the first wait SYNC appear in clock k+12 for a read and k+14 for a write, since the START clock is followed by one type clock, eight address clocks, two data clocks for a write, and two turnaround clocks. The ready SYNC comes one clock after the clock in which the acknowledge is driven. The read nibbles follow in the next two clocks, and two undriven clocks then close the cycle. An abort takes effect on LAD within the same clock. The bench drives each nibble just after the falling edge and reads the outputs 1 ns later, so every comparison lands in the clock its result is due, counted from these figures. It also checks that nothing is driven in every host clock.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDAT_LO,
        ST_WDAT_HI,
        ST_HTAR_A,
        ST_HTAR_B,
        ST_SYNC_WAIT,
        ST_SYNC_OK,
        ST_RDAT_LO,
        ST_RDAT_HI,
        ST_TTAR_A,
        ST_TTAR_B
    } tgt_state_e;

    localparam logic [3:0] START_MEM  = 4'b0000;
    localparam logic [1:0] KIND_MEM   = 2'b01;
    localparam logic [3:0] SYNC_READY = 4'b0000;
    localparam logic [3:0] SYNC_SHORT = 4'b0101;
    localparam logic [3:0] IDLE_NIB   = 4'b1111;

endpackage

// File: rtl/lpc_frame_watch.sv
module lpc_frame_watch
    import lpc_tgt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lframe_n,
    input  logic [3:0] lad_in,
    output logic       frame_end,
    output logic       start_is_mem
);

    logic       armed_q;
    logic [3:0] start_q;

    // Keeps the nibble of the most recent clock with the strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            start_q <= IDLE_NIB;
        end else if (!lframe_n) begin
            armed_q <= 1'b1;
            start_q <= lad_in;
        end else begin
            armed_q <= 1'b0;
        end
    end

    assign frame_end    = lframe_n && armed_q;
    assign start_is_mem = (start_q == START_MEM);

    // R2: a frame ends on a single clock only
    p_frame_end_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

endmodule

// File: rtl/lpc_field_shift.sv
module lpc_field_shift #(
    parameter int ADDR_W = 32,
    parameter int ID_LSB = 22,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_shift,
    input  logic              dlo_load,
    input  logic              dhi_load,
    input  logic [3:0]        lad_in,
    input  logic [ID_W-1:0]   id_strap,
    output logic [ADDR_W-1:0] addr_q,
    output logic              id_hit_next,
    output logic [7:0]        wdata_q
);

    logic [ADDR_W-1:0] addr_next;

    assign addr_next   = {addr_q[ADDR_W-5:0], lad_in};
    assign id_hit_next = (addr_next[ID_LSB +: ID_W] == id_strap);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            if (addr_shift) addr_q       <= addr_next;
            if (dlo_load)   wdata_q[3:0] <= lad_in;
            if (dhi_load)   wdata_q[7:4] <= lad_in;
        end
    end

endmodule

// File: rtl/lpc_lad_drive.sv
module lpc_lad_drive
    import lpc_tgt_pkg::*;
(
    input  tgt_state_e state_q,
    input  logic       lframe_n,
    input  logic [7:0] rdata_q,
    output logic [3:0] lad_out,
    output logic       lad_oe
);

    logic drive_phase;

    always_comb begin
        drive_phase = 1'b0;
        lad_out     = IDLE_NIB;
        unique case (state_q)
            ST_SYNC_WAIT: begin drive_phase = 1'b1; lad_out = SYNC_SHORT;   end
            ST_SYNC_OK:   begin drive_phase = 1'b1; lad_out = SYNC_READY;   end
            ST_RDAT_LO:   begin drive_phase = 1'b1; lad_out = rdata_q[3:0]; end
            ST_RDAT_HI:   begin drive_phase = 1'b1; lad_out = rdata_q[7:4]; end
            default:      begin drive_phase = 1'b0; lad_out = IDLE_NIB;     end
        endcase
    end

    // Abort releases the bus within the same clock.
    assign lad_oe = drive_phase && lframe_n;

endmodule

// File: rtl/lpc_mem_target.sv
module lpc_mem_target
    import lpc_tgt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ID_LSB = 22,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lframe_n,
    input  logic [3:0]        lad_in,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    input  logic [ID_W-1:0]   id_strap,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata
);

    localparam int ADDR_NIB  = ADDR_W / 4;
    localparam int CNT_W     = $clog2(ADDR_NIB);
    localparam logic [CNT_W-1:0] LAST_NIB = CNT_W'(ADDR_NIB - 1);

    tgt_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic            we_q, we_d;
    logic [7:0]      rdata_q;

    logic frame_end, start_is_mem, id_hit_next;
    logic addr_shift, dlo_load, dhi_load;

    lpc_frame_watch u_watch (
        .clk          (clk),
        .rst_n        (rst_n),
        .lframe_n     (lframe_n),
        .lad_in       (lad_in),
        .frame_end    (frame_end),
        .start_is_mem (start_is_mem)
    );

    lpc_field_shift #(
        .ADDR_W (ADDR_W),
        .ID_LSB (ID_LSB),
        .ID_W   (ID_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_shift  (addr_shift),
        .dlo_load    (dlo_load),
        .dhi_load    (dhi_load),
        .lad_in      (lad_in),
        .id_strap    (id_strap),
        .addr_q      (mem_addr),
        .id_hit_next (id_hit_next),
        .wdata_q     (mem_wdata)
    );

    lpc_lad_drive u_drive (
        .state_q  (state_q),
        .lframe_n (lframe_n),
        .rdata_q  (rdata_q),
        .lad_out  (lad_out),
        .lad_oe   (lad_oe)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        we_d    = we_q;
        if (!lframe_n) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_d = '0;
                    if (frame_end && start_is_mem && lad_in[3:2] == KIND_MEM) begin
                        state_d = ST_ADDR;
                        we_d    = lad_in[1];
                    end
                end
                ST_ADDR: begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == LAST_NIB) begin
                        if (!id_hit_next) state_d = ST_IDLE;
                        else if (we_q)    state_d = ST_WDAT_LO;
                        else              state_d = ST_HTAR_A;
                    end
                end
                ST_WDAT_LO:   state_d = ST_WDAT_HI;
                ST_WDAT_HI:   state_d = ST_HTAR_A;
                ST_HTAR_A:    state_d = ST_HTAR_B;
                ST_HTAR_B:    state_d = ST_SYNC_WAIT;
                ST_SYNC_WAIT: if (mem_ack) state_d = ST_SYNC_OK;
                ST_SYNC_OK:   state_d = we_q ? ST_TTAR_A : ST_RDAT_LO;
                ST_RDAT_LO:   state_d = ST_RDAT_HI;
                ST_RDAT_HI:   state_d = ST_TTAR_A;
                ST_TTAR_A:    state_d = ST_TTAR_B;
                ST_TTAR_B:    state_d = ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            we_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            we_q    <= we_d;
            if (mem_req && mem_ack) rdata_q <= mem_rdata;
        end
    end

    // Outputs and field strobes
    always_comb begin
        mem_req    = (state_q == ST_SYNC_WAIT);
        mem_we     = we_q;
        addr_shift = lframe_n && (state_q == ST_ADDR);
        dlo_load   = lframe_n && (state_q == ST_WDAT_LO);
        dhi_load   = lframe_n && (state_q == ST_WDAT_HI);
    end

    // R8: request held until acknowledged
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && lframe_n |=> mem_req);

    // R8: short-wait SYNC on the bus while the request is open
    p_wait_nibble_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && lframe_n |-> lad_oe && lad_out == SYNC_SHORT);

    // R9: ready SYNC follows the acknowledge
    p_ready_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && lframe_n |=> !mem_req && lad_out == SYNC_READY);

    // R11: after an abort clock nothing is requested or driven
    p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !lframe_n |=> !mem_req && !lad_oe);

endmodule

// File: tb/lpc_mem_target_test.sv
module lpc_mem_target_test;

    localparam logic [3:0] MY_ID = 4'hA;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lframe_n;
    logic [3:0]  lad_in;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lpc_mem_target uut (
        .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_in(lad_in),
        .lad_out(lad_out), .lad_oe(lad_oe), .id_strap(MY_ID),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic lf, input logic [3:0] nib);
        @(negedge clk);
        lframe_n = lf;
        lad_in   = nib;
        #1;
    endtask

    task automatic host_quiet(input string tag);
        chk(lad_oe == 1'b0, {tag, " R12 no drive in host phase"}, 32'(lad_oe), 32'd0);
        chk(mem_req == 1'b0, {tag, " no request in host phase"}, 32'(mem_req), 32'd0);
    endtask

    function automatic bit expect_resp(input logic [3:0] st, input logic [3:0] ct, input logic [31:0] addr);
        return (st == 4'b0000) && (ct[3:2] == 2'b01) && (addr[25:22] == MY_ID);
    endfunction

    task automatic do_cycle(input logic [3:0] pre, input logic [3:0] st, input logic [3:0] ct,
                            input logic [31:0] addr, input logic [7:0] wd, input logic [7:0] rd,
                            input int wait_n, input bit skip_start,
                            input int abort_addr, input int abort_wait);
        bit resp;
        bit wr;
        resp = expect_resp(st, ct, addr);
        wr   = ct[1];
        if (!skip_start) begin
            drive(1'b0, pre);
            chk(lad_oe == 1'b0, "R11 no drive while frame low", 32'(lad_oe), 32'd0);
            drive(1'b0, st);
        end
        drive(1'b1, ct);
        host_quiet("R3 type");
        for (int i = 0; i < 8; i++) begin
            if (i == abort_addr) begin
                drive(1'b0, 4'h0);
                chk(lad_oe == 1'b0, "R11 abort in address", 32'(lad_oe), 32'd0);
                return;
            end
            drive(1'b1, addr[31-4*i -: 4]);
            host_quiet("R4 addr");
        end
        if (wr) begin
            drive(1'b1, wd[3:0]); host_quiet("R6 data lo");
            drive(1'b1, wd[7:4]); host_quiet("R6 data hi");
        end
        drive(1'b1, 4'hF); host_quiet("R7 tar a");
        drive(1'b1, 4'hF); host_quiet("R7 tar b");
        if (!resp) begin
            for (int i = 0; i < 4; i++) begin
                drive(1'b1, 4'($urandom));
                host_quiet("R2 R3 R5 ignored cycle");
            end
            return;
        end
        for (int i = 0; i <= wait_n; i++) begin
            if (i == abort_wait) begin
                drive(1'b0, 4'h0);
                chk(lad_oe == 1'b0, "R11 abort releases LAD", 32'(lad_oe), 32'd0);
                return;
            end
            drive(1'b1, 4'hF);
            chk(mem_req == 1'b1, "R8 request open", 32'(mem_req), 32'd1);
            chk(lad_oe && lad_out == 4'b0101, "R8 short wait sync", {27'd0, lad_oe, lad_out}, 32'h15);
            chk(mem_addr == addr, "R4 address", mem_addr, addr);
            chk(mem_we == wr, "R3 direction", 32'(mem_we), 32'(wr));
            if (wr) chk(mem_wdata == wd, "R6 write data", 32'(mem_wdata), 32'(wd));
            if (i == wait_n) begin
                mem_ack   = 1'b1;
                mem_rdata = rd;
            end
        end
        drive(1'b1, 4'hF);
        mem_ack   = 1'b0;
        mem_rdata = 8'($urandom);
        chk(lad_oe && lad_out == 4'b0000 && !mem_req, "R9 ready sync",
            {26'd0, mem_req, lad_oe, lad_out}, 32'h10);
        if (!wr) begin
            drive(1'b1, 4'hF);
            chk(lad_oe && lad_out == rd[3:0], "R10 read lo", {27'd0, lad_oe, lad_out}, {27'd1, rd[3:0]});
            drive(1'b1, 4'hF);
            chk(lad_oe && lad_out == rd[7:4], "R10 read hi", {27'd0, lad_oe, lad_out}, {27'd1, rd[7:4]});
        end
        drive(1'b1, 4'hF);
        chk(lad_oe == 1'b0, "R10 turnaround a", 32'(lad_oe), 32'd0);
        drive(1'b1, 4'hF);
        chk(lad_oe == 1'b0, "R10 turnaround b", 32'(lad_oe), 32'd0);
        drive(1'b1, 4'hF);
        host_quiet("R12 idle after cycle");
    endtask

    function automatic logic [31:0] mk_addr(input logic [31:0] raw, input logic [3:0] id);
        logic [31:0] a;
        a = raw;
        a[25:22] = id;
        return a;
    endfunction

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; lframe_n = 1'b1; lad_in = 4'hF; mem_ack = 1'b0; mem_rdata = 8'h00;
        repeat (3) drive(1'b1, 4'hF);
        chk(lad_oe == 1'b0 && mem_req == 1'b0, "R1 reset outputs", {30'd0, lad_oe, mem_req}, 32'd0);
        rst_n = 1'b1;
        drive(1'b1, 4'h3);
        chk(lad_oe == 1'b0 && mem_req == 1'b0, "R1 after reset", {30'd0, lad_oe, mem_req}, 32'd0);

        // directed: read, write, zero-wait and long-wait
        do_cycle(4'h7, 4'h0, 4'b0100, mk_addr(32'hFFF0_1234, MY_ID), 8'h00, 8'hC3, 0, 1'b0, -1, -1);
        do_cycle(4'h0, 4'h0, 4'b0110, mk_addr(32'h1234_5678, MY_ID), 8'h5A, 8'h00, 3, 1'b0, -1, -1);
        // R2: last low nibble is nonzero after a zero
        do_cycle(4'h0, 4'h9, 4'b0100, mk_addr(32'h0000_0000, MY_ID), 8'h00, 8'h11, 0, 1'b0, -1, -1);
        // R3: I/O type ignored
        do_cycle(4'h0, 4'h0, 4'b0000, mk_addr(32'hABCD_0000, MY_ID), 8'h00, 8'h11, 0, 1'b0, -1, -1);
        // R5: other ID ignored
        do_cycle(4'h0, 4'h0, 4'b0110, mk_addr(32'h8765_4321, 4'h5), 8'h77, 8'h00, 0, 1'b0, -1, -1);
        // R11: abort during SYNC, abort nibble starts the next cycle
        do_cycle(4'h0, 4'h0, 4'b0100, mk_addr(32'h0F0F_0F0F, MY_ID), 8'h00, 8'h00, 3, 1'b0, -1, 1);
        do_cycle(4'h0, 4'h0, 4'b0100, mk_addr(32'h3333_3333, MY_ID), 8'h00, 8'h96, 1, 1'b1, -1, -1);
        // R11: abort in address phase
        do_cycle(4'h0, 4'h0, 4'b0110, mk_addr(32'h2222_2222, MY_ID), 8'h44, 8'h00, 0, 1'b0, 4, -1);
        do_cycle(4'h0, 4'h0, 4'b0110, mk_addr(32'h4444_4444, MY_ID), 8'hE1, 8'h00, 2, 1'b1, -1, -1);

        for (int n = 0; n < 40; n++) begin
            logic [3:0]  st, ct;
            logic [31:0] a;
            st = ($urandom % 6 == 0) ? 4'($urandom) : 4'h0;
            ct = ($urandom % 5 == 0) ? 4'($urandom) : {2'b01, 1'($urandom), 1'b0};
            a  = $urandom;
            if ($urandom % 5 != 0) a = mk_addr(a, MY_ID);
            do_cycle(4'($urandom), st, ct, a, 8'($urandom), 8'($urandom), int'($urandom % 4),
                     1'b0, -1, -1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule